// File: doc/BRIEF.md
# Clock-Stop SPI Master Serializer

This block is a single-word SPI master. A one-cycle start strobe captures a parallel transmit word, a word length and a clock divisor. The block then drives an active-low slave select, a gated serial clock and a serial data output with its own output-enable. It samples the serial data input and, when the transfer is over, presents the received word with a one-cycle done pulse.

The serial clock exists only while slave select is low and idles low otherwise. Its period and its uneven low and high phases come from the divisor. All timing is counted in core-clock cycles.

The unit used below is one core-clock cycle, which is two core half-periods. Let DIV be the divisor in use, with 0 taken as 1. The low-phase width is L, the high-phase width is H, and the period is T = L + H. N is the word length in use.

Top module: `spi_cs_master`

## Requirements
- R1: The serial clock period T equals 1 + DIV core cycles. A divisor field of 0 is handled as 1.
- R2: When DIV is odd, L and H both equal (DIV+1)/2. When DIV is even, L equals DIV/2 and H equals DIV/2 + 1. Each transfer starts with a low phase.
- R3: Outside a transfer, `ss_n` is 1, `sclk` is 0 and `sdo_oe` is 0. The clock never toggles while `ss_n` is high.
- R4: `ss_n` falls on the first cycle after the clock edge that accepts `start`. The first rising `sclk` edge follows L cycles later, and the first falling edge follows T cycles after `ss_n` falls.
- R5: `sdo_oe` rises with the first rising `sclk` edge. `sdo` changes only on rising edges and carries the transmit word MSB first, that is bit N-1 first. Only bits N-1..0 of `tx_word` are sent.
- R6: `sdi` is sampled at each falling `sclk` edge, MSB first. `rx_word` holds the N received bits in bits N-1..0 and zeros above them.
- R7: The last falling edge, H cycles after the last rising edge, ends the transfer. In that same cycle `ss_n` returns high, `sdo_oe` drops, `busy` drops, `rx_word` is updated and `done` is high for exactly one cycle.
- R8: A transfer makes exactly N rising `sclk` edges. N is `word_len` clamped to the range 8..32, so a value below 8 gives 8 and a value above 32 gives 32.
- R9: A `start` while `busy` is high is ignored. The divisor, the length and the transmit word are taken only when a transfer is accepted, so changing them during a transfer has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transfer request, accepted while idle |
| tx_word | input | 32 | Word to send, bits N-1..0 used |
| word_len | input | 6 | Requested word length in bits |
| clk_div | input | 8 | Clock divisor DIV |
| busy | output | 1 | High from acceptance to end of transfer |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_word | output | 32 | Last received word |
| ss_n | output | 1 | Active-low slave select |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output-enable for the sdo pad driver |
| sdi | input | 1 | Serial data in |

## Verification
The bench checks every cycle of each transfer against a timeline computed from L, H and N. An off-by-one in either phase counter, or swapped low and high widths for an even divisor, therefore shows up as a misplaced clock edge. Divisors 0, 1, 2 and 3 are run directly: a design that does not clamp a divisor of 0 stalls or makes a zero-width phase, and one that splits the period evenly for even divisors shortens the high phase. Lengths of 5 and 40 test the clamping, where a design without it sends the wrong number of clock pulses. A start pulse mid-transfer with new divisor, length and data must leave the timeline and the data untouched, or the frame is restarted or corrupted. The slave model drives a random word that is compared with `rx_word`, which catches a design that samples on the wrong edge or leaves stale upper bits.

// File: rtl/spim_pkg.sv
package spim_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } spim_state_e;
endpackage

// File: rtl/spim_phase_calc.sv
module spim_phase_calc #(
    parameter int DIV_W = 8
) (
    input  logic [DIV_W-1:0] div,
    output logic [DIV_W-1:0] low_w,
    output logic [DIV_W-1:0] high_w
);
    logic [DIV_W-1:0] half_d;

    always_comb begin
        half_d = div >> 1;
        high_w = half_d + 1'b1;
        // an odd divisor splits evenly, an even one gives the extra cycle to high
        low_w  = div[0] ? half_d + 1'b1 : half_d;
    end
endmodule

// File: rtl/spim_tx_shift.sv
module spim_tx_shift #(
    parameter int MAX_W = 32,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic [MAX_W-1:0] word,
    input  logic             shift,
    output logic             msb
);
    logic [MAX_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d = word << (LEN_W'(MAX_W) - len);
        end else if (shift) begin
            sh_d = {sh_q[MAX_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign msb = sh_q[MAX_W-1];
endmodule

// File: rtl/spim_rx_shift.sv
module spim_rx_shift #(
    parameter int MAX_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic             last,
    input  logic             sdi,
    output logic [MAX_W-1:0] word
);
    logic [MAX_W-1:0] sh_d, sh_q, word_d, word_q;

    always_comb begin
        sh_d   = sh_q;
        word_d = word_q;
        if (clear) begin
            sh_d = '0;
        end else if (sample) begin
            sh_d = {sh_q[MAX_W-2:0], sdi};
            if (last) word_d = sh_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            word_q <= '0;
        end else begin
            sh_q   <= sh_d;
            word_q <= word_d;
        end
    end

    assign word = word_q;
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master #(
    parameter int MAX_W = 32,
    parameter int MIN_W = 8,
    parameter int DIV_W = 8,
    parameter int LEN_W = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [MAX_W-1:0] tx_word,
    input  logic [LEN_W-1:0] word_len,
    input  logic [DIV_W-1:0] clk_div,
    output logic             busy,
    output logic             done,
    output logic [MAX_W-1:0] rx_word,
    output logic             ss_n,
    output logic             sclk,
    output logic             sdo,
    output logic             sdo_oe,
    input  logic             sdi
);
    import spim_pkg::*;

    typedef struct packed {
        spim_state_e      state;
        logic [DIV_W-1:0] cnt;
        logic [LEN_W-1:0] bits;
        logic [DIV_W-1:0] div;
        logic             sclk;
        logic             ss_n;
        logic             oe;
        logic             sdo;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [LEN_W-1:0] len_eff;
    logic [DIV_W-1:0] div_in_eff, div_sel, low_w, high_w;
    logic             tx_load, tx_shift, tx_msb;
    logic             rx_sample, rx_last;

    spim_phase_calc #(.DIV_W(DIV_W)) i_phase (
        .div    (div_sel),
        .low_w  (low_w),
        .high_w (high_w)
    );

    spim_tx_shift #(.MAX_W(MAX_W), .LEN_W(LEN_W)) i_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tx_load),
        .len   (len_eff),
        .word  (tx_word),
        .shift (tx_shift),
        .msb   (tx_msb)
    );

    spim_rx_shift #(.MAX_W(MAX_W)) i_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (tx_load),
        .sample (rx_sample),
        .last   (rx_last),
        .sdi    (sdi),
        .word   (rx_word)
    );

    always_comb begin
        if (word_len < LEN_W'(MIN_W))      len_eff = LEN_W'(MIN_W);
        else if (word_len > LEN_W'(MAX_W)) len_eff = LEN_W'(MAX_W);
        else                               len_eff = word_len;
        div_in_eff = (clk_div == '0) ? DIV_W'(1) : clk_div;
        // while idle the widths describe the incoming divisor, else the held one
        div_sel    = (ctl_q.state == ST_IDLE) ? div_in_eff : ctl_q.div;

        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tx_load    = 1'b0;
        tx_shift   = 1'b0;
        rx_sample  = 1'b0;
        rx_last    = 1'b0;

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.state = ST_LOW;
                    ctl_d.ss_n  = 1'b0;
                    ctl_d.div   = div_in_eff;
                    ctl_d.cnt   = low_w - 1'b1;
                    ctl_d.bits  = len_eff - 1'b1;
                    tx_load     = 1'b1;
                end
            end
            ST_LOW: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.state = ST_HIGH;
                    ctl_d.sclk  = 1'b1;
                    ctl_d.sdo   = tx_msb;
                    ctl_d.oe    = 1'b1;
                    ctl_d.cnt   = high_w - 1'b1;
                    tx_shift    = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_HIGH: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.sclk = 1'b0;
                    rx_sample  = 1'b1;
                    if (ctl_q.bits == '0) begin
                        rx_last     = 1'b1;
                        ctl_d.state = ST_IDLE;
                        ctl_d.ss_n  = 1'b1;
                        ctl_d.oe    = 1'b0;
                        ctl_d.done  = 1'b1;
                    end else begin
                        ctl_d.state = ST_LOW;
                        ctl_d.bits  = ctl_q.bits - 1'b1;
                        ctl_d.cnt   = low_w - 1'b1;
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
            ctl_q.ss_n  <= 1'b1;
            ctl_q.div   <= DIV_W'(1);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy   = (ctl_q.state != ST_IDLE);
    assign done   = ctl_q.done;
    assign ss_n   = ctl_q.ss_n;
    assign sclk   = ctl_q.sclk;
    assign sdo    = ctl_q.sdo;
    assign sdo_oe = ctl_q.oe;

    // R3: clock parked low whenever the slave is deselected
    a_r3_clk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> !sclk);
    // R5: data driver enabled only inside a frame
    a_r5_oe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> !ss_n);
    // R5: data moves only together with a rising clock
    a_r5_sdo_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe) && !$rose(sclk)) |-> $stable(sdo));
    // R7: done lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: done coincides with release of the select and end of busy
    a_r7_done_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($rose(ss_n) && !busy && !sdo_oe));
    // R2: high phase equals low phase or exceeds it by one
    a_r2_phase_balance: assert property (@(posedge clk) disable iff (!rst_n)
        (high_w == low_w) || (high_w == low_w + 1'b1));
    // R9: a start during a transfer leaves the held divisor alone
    a_r9_div_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(ctl_q.div));
endmodule

// File: tb/test_spi_cs_master.sv
module test_spi_cs_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] tx_word = '0;
    logic [5:0]  word_len = 6'd8;
    logic [7:0]  clk_div = 8'd1;
    logic        busy, done, ss_n, sclk, sdo, sdo_oe;
    logic        sdi = 1'b0;
    logic [31:0] rx_word;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spi_cs_master i_spi_cs_master (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
        .word_len(word_len), .clk_div(clk_div), .busy(busy), .done(done),
        .rx_word(rx_word), .ss_n(ss_n), .sclk(sclk), .sdo(sdo),
        .sdo_oe(sdo_oe), .sdi(sdi)
    );

    function automatic int eff_div(input int d);
        return (d == 0) ? 1 : d;
    endfunction
    function automatic int lo_w(input int d);
        int e = eff_div(d);
        return (e % 2 == 1) ? (e + 1) / 2 : e / 2;
    endfunction
    function automatic int hi_w(input int d);
        return eff_div(d) / 2 + 1;
    endfunction
    function automatic int eff_len(input int l);
        return (l < 8) ? 8 : ((l > 32) ? 32 : l);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            if (errors < 30)
                $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic xfer(input logic [31:0] tx, input int len_in, input int div_in, input int poke);
        int n = eff_len(len_in);
        int l = lo_w(div_in);
        int h = hi_w(div_in);
        int t = l + h;
        int rises = 0;
        int first_rise = -1;
        int second_rise = -1;
        int err0 = errors;
        logic [31:0] slv = $urandom;
        logic [63:0] mask = (64'd1 << n) - 64'd1;
        logic prev_sclk = 1'b0;
        @(negedge clk);
        start = 1'b1; tx_word = tx; word_len = 6'(len_in); clk_div = 8'(div_in);
        @(negedge clk);
        start = 1'b0;
        // R9: inputs move after acceptance and must not matter
        tx_word = $urandom; word_len = 6'($urandom % 64); clk_div = 8'($urandom % 16);
        for (int k = 0; k <= n * t; k++) begin
            bit fin = (k == n * t);
            bit e_sclk = !fin && ((k % t) >= l);
            bit e_oe = !fin && (k >= l);
            if (k > 0) @(negedge clk);
            if (sclk && !prev_sclk) begin
                rises++;
                if (first_rise < 0) first_rise = k; else if (second_rise < 0) second_rise = k;
            end
            prev_sclk = sclk;
            check(sclk === e_sclk, "R2 sclk phase", sclk, e_sclk);
            check(ss_n === fin, "R4 ss_n", ss_n, fin);
            check(sdo_oe === e_oe, "R5 sdo_oe", sdo_oe, e_oe);
            if (e_oe) check(sdo === tx[n - 1 - (k - l) / t], "R5 sdo bit", sdo, tx[n - 1 - (k - l) / t]);
            check(busy === !fin, "R7 busy", busy, !fin);
            check(done === fin, "R7 done", done, fin);
            if (k == poke) begin
                start = 1'b1; tx_word = $urandom; clk_div = 8'($urandom % 16);
                word_len = 6'($urandom % 64);
            end else begin
                start = 1'b0;
            end
            if (!fin) sdi = slv[n - 1 - k / t];
        end
        check(first_rise == l, "R4 first rise", first_rise, l);
        check(second_rise - first_rise == t, "R1 period", second_rise - first_rise, t);
        check(rises == n, "R8 rising edges", rises, n);
        check(rx_word === (slv & mask[31:0]), "R6 rx_word", rx_word, slv & mask[31:0]);
        @(negedge clk);
        check(!done && ss_n && !sclk && !sdo_oe, "R3 idle after",
              {done, ss_n, sclk, sdo_oe}, 4'b0100);
        if (poke >= 0) check(errors == err0, "R9 start while busy", errors - err0, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(ss_n === 1'b1 && sclk === 1'b0 && sdo_oe === 1'b0, "R3 reset lines",
              {ss_n, sclk, sdo_oe}, 3'b100);
        check(busy === 1'b0 && done === 1'b0 && rx_word === '0, "R7 reset status",
              {busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        xfer(32'h0000_00A5, 8, 0, -1);      // R1 divisor 0 handled as 1
        xfer(32'h0000_005A, 8, 1, -1);
        xfer(32'h0000_0C3F, 12, 2, -1);     // R2 even divisor
        xfer(32'h0001_2345, 17, 3, -1);     // R2 odd divisor
        xfer(32'hDEAD_BEEF, 32, 4, -1);
        xfer(32'hFFFF_FF81, 5, 2, -1);      // R8 short length clamped
        xfer(32'h8000_0001, 40, 1, -1);     // R8 long length clamped
        xfer(32'h0000_3C96, 16, 5, 7);      // R9 start while busy
        xfer(32'h0000_00FF, 8, 6, 20);      // R9
        for (int i = 0; i < 30; i++) begin
            xfer($urandom, 8 + ($urandom % 25), $urandom % 13, ($urandom % 2 == 1) ? 3 : -1);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule